// File: doc/BRIEF.md
# Timed-Signal Gate Evaluator

This unit evaluates one logic gate per request on timed signals, words that carry a logic level together with the earliest time at which that level is settled. A caller presents an opcode and up to three operand words. The unit then returns a single result word. The logic value of the result follows from the gate function. The settle time of the result is the latest settle time among the inputs that the gate uses, plus the fixed propagation delay of that gate type. Tools that do worst-case timing can chain results into later requests to find both the final level and the time at which a net becomes stable.

Requests enter through a valid/ready pair. Each accepted request produces one registered result one clock later. The result stays on the output until the consumer takes it. The three gate delays are parameters, so a different technology table can be used without changing the logic. A settle time never wraps into the value bit. If the addition would exceed the largest representable time, the time field saturates and a flag marks the result.

Top module: `tsig_gate_unit`

## Requirements
- R1: A word is TIME_W+1 bits. The top bit is the logic level (1 = high) and the low TIME_W bits hold the settle time. Defaults: 16-bit word, time in bits 14..0.
- R2: Opcode 3'b000 (invert) flips the level bit of operand a and returns its time unchanged, with no delay added.
- R3: Opcode 3'b001 (and) returns a AND b on the level bits, and the larger of the two times, with no delay added.
- R4: Opcode 3'b010 (or) returns a OR b on the level bits, and the larger of the two times, with no delay added.
- R5: Opcode 3'b011 (nand2) returns NOT(a AND b), and the larger of the two times plus DLY_NAND2 (default 9).
- R6: Opcode 3'b100 (or3) returns a OR b OR c, and the largest of the three times plus DLY_OR3 (default 30).
- R7: Opcode 3'b101 (xor2) returns a XOR b, and the larger of the two times plus DLY_XOR2 (default 35).
- R8: When time plus delay exceeds the largest TIME_W-bit value, the time field is all ones, res_ovf is 1 and the level bit is unaffected. Otherwise res_ovf is 0.
- R9: Opcodes 3'b110 and 3'b111 return an all-zero word with res_err 1 and res_ovf 0. res_err is 0 for every other opcode.
- R10: A request is accepted on a clock edge where in_valid and in_ready are both high. Its result appears with out_valid high after that edge. While out_valid is high and out_ready is low, the result and its flags hold, and in_ready is low.
- R11: After reset, out_valid is 0 and in_ready is 1.
- R12: Results can be chained. With a = low@0, b = low@10 and c = high@10, xor2(a,b) is low@45, and or3(nand2(that, c), a, b) is high@84.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| op | input | 3 | Gate opcode |
| opnd_a | input | TIME_W+1 | First operand |
| opnd_b | input | TIME_W+1 | Second operand |
| opnd_c | input | TIME_W+1 | Third operand (or3 only) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res | output | TIME_W+1 | Result word |
| res_ovf | output | 1 | Settle time saturated |
| res_err | output | 1 | Opcode not defined |

## Verification
The bench builds the unit with its default parameters: a 15-bit time field and delays of 9, 30 and 35. With these values the chained example reaches exactly 45 and 84. Operands with times just below and at 0x7FFF push the sum of time and delay across the saturation limit from both sides. This shows the flag set and cleared on adjacent inputs. A stalled consumer exercises the hold of the result and the blocked input.

// File: rtl/tsig_pkg.sv
package tsig_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_INV   = 3'b000,
    OP_AND   = 3'b001,
    OP_OR    = 3'b010,
    OP_NAND2 = 3'b011,
    OP_OR3   = 3'b100,
    OP_XOR2  = 3'b101
  } tsig_op_e;

endpackage

// File: rtl/tsig_rst_sync.sv
module tsig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sr_q[STAGES-1];

endmodule

// File: rtl/tsig_eval.sv
module tsig_eval
  import tsig_pkg::*;
#(
  parameter int TIME_W    = 15,
  parameter int DLY_NAND2 = 9,
  parameter int DLY_OR3   = 30,
  parameter int DLY_XOR2  = 35
) (
  input  logic [OP_W-1:0]   op,
  input  logic [TIME_W:0]   a,
  input  logic [TIME_W:0]   b,
  input  logic [TIME_W:0]   c,
  output logic              lvl,
  output logic [TIME_W-1:0] base_t,
  output logic [TIME_W-1:0] dly,
  output logic              err
);

  localparam int W = TIME_W + 1;

  function automatic logic [W-1:0] p_inv(input logic [W-1:0] x);
    return {~x[W-1], x[W-2:0]};
  endfunction

  function automatic logic [W-1:0] p_and(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [TIME_W-1:0] tm;
    tm = (x[TIME_W-1:0] > y[TIME_W-1:0]) ? x[TIME_W-1:0] : y[TIME_W-1:0];
    return {x[W-1] & y[W-1], tm};
  endfunction

  function automatic logic [W-1:0] p_or(input logic [W-1:0] x, input logic [W-1:0] y);
    return p_inv(p_and(p_inv(x), p_inv(y)));
  endfunction

  logic [W-1:0] raw;

  always_comb begin
    raw = '0;
    dly = '0;
    err = 1'b0;
    case (op)
      OP_INV:   raw = p_inv(a);
      OP_AND:   raw = p_and(a, b);
      OP_OR:    raw = p_or(a, b);
      OP_NAND2: begin
        raw = p_inv(p_and(a, b));
        dly = TIME_W'(DLY_NAND2);
      end
      OP_OR3: begin
        raw = p_or(p_or(a, b), c);
        dly = TIME_W'(DLY_OR3);
      end
      OP_XOR2: begin
        raw = p_or(p_and(a, p_inv(b)), p_and(p_inv(a), b));
        dly = TIME_W'(DLY_XOR2);
      end
      default: err = 1'b1;
    endcase
  end

  assign lvl    = raw[W-1];
  assign base_t = raw[TIME_W-1:0];

endmodule

// File: rtl/tsig_sat_add.sv
module tsig_sat_add #(
  parameter int TIME_W = 15
) (
  input  logic [TIME_W-1:0] base_t,
  input  logic [TIME_W-1:0] dly,
  output logic [TIME_W-1:0] t_out,
  output logic              ovf
);

  logic [TIME_W:0] sum;

  always_comb begin
    sum   = {1'b0, base_t} + {1'b0, dly};
    ovf   = sum[TIME_W];
    t_out = ovf ? '1 : sum[TIME_W-1:0];
  end

endmodule

// File: rtl/tsig_out_stage.sv
module tsig_out_stage #(
  parameter int TIME_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            drain,
  input  logic [TIME_W:0] d_word,
  input  logic            d_ovf,
  input  logic            d_err,
  output logic            q_valid,
  output logic [TIME_W:0] q_word,
  output logic            q_ovf,
  output logic            q_err
);

  logic            nxt_valid;
  logic [TIME_W:0] nxt_word;
  logic            nxt_ovf;
  logic            nxt_err;

  always_comb begin
    nxt_valid = q_valid;
    nxt_word  = q_word;
    nxt_ovf   = q_ovf;
    nxt_err   = q_err;
    if (load) begin
      nxt_valid = 1'b1;
      nxt_word  = d_word;
      nxt_ovf   = d_ovf;
      nxt_err   = d_err;
    end else if (drain) begin
      nxt_valid = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_word  <= '0;
      q_ovf   <= 1'b0;
      q_err   <= 1'b0;
    end else begin
      q_valid <= nxt_valid;
      if (load) begin
        q_word <= nxt_word;
        q_ovf  <= nxt_ovf;
        q_err  <= nxt_err;
      end
    end
  end

  // R9
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_err) |-> (q_word == '0 && !q_ovf));

  // R8
  sat_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_ovf) |-> (&q_word[TIME_W-1:0]));

endmodule

// File: rtl/tsig_gate_unit.sv
module tsig_gate_unit
  import tsig_pkg::*;
#(
  parameter int TIME_W    = 15,
  parameter int DLY_NAND2 = 9,
  parameter int DLY_OR3   = 30,
  parameter int DLY_XOR2  = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   op,
  input  logic [TIME_W:0]   opnd_a,
  input  logic [TIME_W:0]   opnd_b,
  input  logic [TIME_W:0]   opnd_c,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TIME_W:0]   res,
  output logic              res_ovf,
  output logic              res_err
);

  localparam int WORD_W = TIME_W + 1;

  logic              rst_s_n;
  logic              accept;
  logic              e_lvl;
  logic [TIME_W-1:0] e_base;
  logic [TIME_W-1:0] e_dly;
  logic              e_err;
  logic [TIME_W-1:0] s_time;
  logic              s_ovf;
  logic [WORD_W-1:0] d_word;
  logic              d_ovf;

  tsig_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign in_ready = rst_s_n & (~out_valid | out_ready);
  assign accept   = in_valid & in_ready;

  tsig_eval #(
    .TIME_W    (TIME_W),
    .DLY_NAND2 (DLY_NAND2),
    .DLY_OR3   (DLY_OR3),
    .DLY_XOR2  (DLY_XOR2)
  ) u_eval (
    .op     (op),
    .a      (opnd_a),
    .b      (opnd_b),
    .c      (opnd_c),
    .lvl    (e_lvl),
    .base_t (e_base),
    .dly    (e_dly),
    .err    (e_err)
  );

  tsig_sat_add #(.TIME_W(TIME_W)) u_add (
    .base_t (e_base),
    .dly    (e_dly),
    .t_out  (s_time),
    .ovf    (s_ovf)
  );

  assign d_word = e_err ? '0 : {e_lvl, s_time};
  assign d_ovf  = s_ovf & ~e_err;

  tsig_out_stage #(.TIME_W(TIME_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load    (accept),
    .drain   (out_ready),
    .d_word  (d_word),
    .d_ovf   (d_ovf),
    .d_err   (e_err),
    .q_valid (out_valid),
    .q_word  (res),
    .q_ovf   (res_ovf),
    .q_err   (res_err)
  );

  // R10
  hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res) && $stable(res_ovf) && $stable(res_err)));

  // R10
  launch_result_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && in_ready) |=> out_valid);

  // R2
  inv_keeps_time_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && in_ready && op == OP_INV) |=>
      (res[TIME_W-1:0] == $past(opnd_a[TIME_W-1:0]) && res[TIME_W] != $past(opnd_a[TIME_W])));

  // R3
  and_latest_time_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && in_ready && op == OP_AND) |=>
      (res[TIME_W-1:0] >= $past(opnd_a[TIME_W-1:0]) && res[TIME_W-1:0] >= $past(opnd_b[TIME_W-1:0])));

endmodule

// File: tb/tsig_gate_unit_test.sv
`timescale 1ns/1ps
module tsig_gate_unit_test;

  localparam int TW = 15;
  localparam int MAXT = (1 << TW) - 1;

  typedef struct {
    logic [TW+2:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [2:0]    op;
  logic [TW:0]   opnd_a, opnd_b, opnd_c;
  logic          out_valid;
  logic          out_ready;
  logic [TW:0]   res;
  logic          res_ovf;
  logic          res_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t sb[$];

  always #4 clk = ~clk;

  tsig_gate_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .out_valid(out_valid), .out_ready(out_ready),
    .res(res), .res_ovf(res_ovf), .res_err(res_err)
  );

  function automatic int tmax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // expected {err, ovf, level, time} from the requirement text
  function automatic logic [TW+2:0] model(input logic [2:0] o, input logic [TW:0] a,
                                          input logic [TW:0] b, input logic [TW:0] c);
    int ta, tb, tc, t, d;
    logic va, vb, vc, v, ov;
    ta = int'(a[TW-1:0]); tb = int'(b[TW-1:0]); tc = int'(c[TW-1:0]);
    va = a[TW]; vb = b[TW]; vc = c[TW];
    d = 0;
    case (o)
      3'd0: begin v = !va;          t = ta; end
      3'd1: begin v = va && vb;     t = tmax(ta, tb); end
      3'd2: begin v = va || vb;     t = tmax(ta, tb); end
      3'd3: begin v = !(va && vb);  t = tmax(ta, tb); d = 9; end
      3'd4: begin v = va || vb || vc; t = tmax(tmax(ta, tb), tc); d = 30; end
      3'd5: begin v = va ^ vb;      t = tmax(ta, tb); d = 35; end
      default: return {1'b1, 1'b0, {(TW+1){1'b0}}};
    endcase
    t = t + d;
    ov = (t > MAXT);
    if (ov) t = MAXT;
    return {1'b0, ov, v, TW'(t)};
  endfunction

  function automatic void check(input string tag, input logic [TW+2:0] act, input logic [TW+2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  task automatic send(input logic [2:0] o, input logic [TW:0] a, input logic [TW:0] b,
                      input logic [TW:0] c, input string tag);
    item_t it;
    it.exp = model(o, a, b, c);
    it.tag = tag;
    sb.push_back(it);
    op = o; opnd_a = a; opnd_b = b; opnd_c = c;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pop and compare on every handshake
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected result actual=%h expected=none", res);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, {res_err, res_ovf, res}, it.exp);
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TW:0] held;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    op = '0; opnd_a = '0; opnd_b = '0; opnd_c = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 out_valid", {17'd0, out_valid}, 18'd0);
    check("R11 in_ready", {17'd0, in_ready}, 18'd1);

    // R1 R2 invert
    send(3'd0, 16'h0005, 16'h0, 16'h0, "R2 inv low");
    send(3'd0, 16'h8123, 16'h0, 16'h0, "R2 inv high");
    // R3 and
    send(3'd1, 16'h8010, 16'h8020, 16'h0, "R3 and hh");
    send(3'd1, 16'h8030, 16'h0004, 16'h0, "R3 and hl");
    // R4 or
    send(3'd2, 16'h0007, 16'h8003, 16'h0, "R4 or lh");
    send(3'd2, 16'h0001, 16'h0002, 16'h0, "R4 or ll");
    // R5 nand2
    send(3'd3, 16'h8010, 16'h8008, 16'h0, "R5 nand hh");
    send(3'd3, 16'h0010, 16'h8000, 16'h0, "R5 nand lh");
    // R6 or3
    send(3'd4, 16'h0000, 16'h0000, 16'h0005, "R6 or3 lll");
    send(3'd4, 16'h0000, 16'h8004, 16'h0002, "R6 or3 lhl");
    // R7 xor2
    send(3'd5, 16'h8000, 16'h0003, 16'h0, "R7 xor hl");
    send(3'd5, 16'h8001, 16'h8001, 16'h0, "R7 xor hh");
    // R8 saturation edges
    send(3'd3, 16'h7FF0, 16'h0000, 16'h0, "R8 below limit");
    send(3'd3, 16'h7FFA, 16'h0000, 16'h0, "R8 nand over");
    send(3'd5, 16'h7FFF, 16'h0000, 16'h0, "R8 xor over");
    send(3'd0, 16'h7FFF, 16'h0000, 16'h0, "R8 inv at max");
    // R9 undefined opcodes
    send(3'd6, 16'h8123, 16'h8456, 16'h8789, "R9 op6");
    send(3'd7, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R9 op7");
    // R12 chained example, literal expectations
    send(3'd5, 16'h0000, 16'h000A, 16'h0, "R12 xor step");
    check("R12 xor literal", model(3'd5, 16'h0000, 16'h000A, 16'h0), 18'h0002D);
    send(3'd3, 16'h002D, 16'h800A, 16'h0, "R12 nand step");
    send(3'd4, 16'h8036, 16'h0000, 16'h000A, "R12 or3 step");
    check("R12 or3 literal", model(3'd4, 16'h8036, 16'h0000, 16'h000A), 18'h08054);

    // R10 back-pressure: result must hold and input must block
    @(negedge clk);
    out_ready = 1'b0;
    send(3'd1, 16'h8111, 16'h8222, 16'h0, "R10 stalled and");
    check("R10 valid while stalled", {17'd0, out_valid}, 18'd1);
    check("R10 in_ready low while stalled", {17'd0, in_ready}, 18'd0);
    held = res;
    repeat (3) @(negedge clk);
    check("R10 result held", {2'b0, res}, {2'b0, held});
    check("R10 still valid", {17'd0, out_valid}, 18'd1);
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 drained", {17'd0, out_valid}, 18'd0);

    for (int i = 0; i < 50 && sb.size() != 0; i++) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10 results missing actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule